// File: doc/BRIEF.md
# Delay-Chain Period Encoder

This block measures how long one reference period lasts, expressed as a whole number of range delay units. It also turns that number into a coarse range selection for a digitally controlled delay line. An outside chain of delay units is driven by a measurement pulse that stays high for one reference period. The block watches that pulse on its clock. When it first sees the pulse low after a high, it takes a registered picture of every tap of the chain.

The picture is a thermometer code. The block counts the unbroken run of ones that starts at tap 0; any stray ones above the first zero are discarded. It then picks the narrowest of four delay ranges whose programmed upper limit still covers that count. Because the delay line starts in a range that only just spans one period, the loop that follows cannot settle on two or more periods. The result is announced by a one-cycle done strobe. From then on the result is frozen, and further pulses are ignored until the next reset. If the whole chain is high at capture, the period is longer than the chain can measure: the code goes to the widest range and an overflow flag is raised.

Top module: `delay_chain_encoder`

## Requirements
- R1: While and right after reset, the snapshot, unit count, range code, overflow flag and done strobe are all 0.
- R2: The snapshot takes the tap vector present at the first clock edge where the measurement pulse is sampled low after being sampled high. Tap values before that edge, and tap changes after it, do not alter the snapshot.
- R3: The unit count equals the number of consecutive ones in the snapshot starting at tap 0. Any ones above the first zero are ignored.
- R4: The range limits input holds four unsigned counts, with entry r at bits [r*COUNT_W +: COUNT_W]. The range code is the smallest r whose limit is greater than or equal to the unit count. If no limit is that large, the code is 3.
- R5: When every tap in the snapshot is 1, the unit count equals NUM_TAPS, the overflow flag is 1 and the range code is 3, whatever the limits are.
- R6: The done strobe is high for exactly one cycle, one clock after the snapshot edge. Count, code and overflow are valid in that same cycle.
- R7: After the done strobe, the snapshot, count, code and overflow hold their values, and no further done strobe occurs until reset, even if more pulses or tap changes arrive.
- R8: A reset after a finished measurement clears all results and allows a fresh measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Asynchronous reset, active high |
| measPulse | input | 1 | Measurement pulse; its falling edge triggers the capture |
| tapIn | input | NUM_TAPS | Outputs of the range delay units, tap 0 nearest the pulse source |
| rangeLimits | input | NUM_RANGES*COUNT_W | Programmed upper unit count for each range |
| tapSnapshot | output | NUM_TAPS | Registered tap picture |
| unitCount | output | COUNT_W | Period in range delay units |
| rangeCode | output | CODE_W | Selected delay range |
| chainOverflow | output | 1 | Period longer than the chain |
| measDone | output | 1 | One-cycle result strobe |

## Verification
Call the clock edge where the pulse is first sampled low the capture edge. The snapshot is due just after the capture edge. Count, code, overflow and the done strobe are due one edge later, and the strobe must be gone after the edge after that. The bench changes inputs only on falling clock edges. It reads each result in the half-cycle after the edge where it is due, and it changes the taps right after capture so that a late capture would show up as a wrong value. Every run length from 0 to 16 is swept, with bubbles, under three sets of limits, and each run then fires a second pulse to check that nothing moves.

// File: rtl/chain_enc_pkg.sv
package chain_enc_pkg;
  typedef struct packed {
    logic capture;
    logic load;
  } ctrlStrobes_t;
endpackage

// File: rtl/chain_enc_ctrl.sv
module chain_enc_ctrl
  import chain_enc_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         measPulse,
  output ctrlStrobes_t strobes,
  output logic         locked
);
  typedef enum logic [1:0] {ST_WAIT, ST_ENCODE, ST_HOLD} state_t;

  state_t state;
  logic   pulseQ;
  logic   fallSeen;

  assign fallSeen = pulseQ && !measPulse;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state  <= ST_WAIT;
      pulseQ <= 1'b0;
    end else begin
      pulseQ <= measPulse;
      case (state)
        ST_WAIT:   if (fallSeen) state <= ST_ENCODE;
        ST_ENCODE: state <= ST_HOLD;
        default:   state <= ST_HOLD;
      endcase
    end
  end

  always_comb begin
    strobes.capture = (state == ST_WAIT) && fallSeen;
    strobes.load    = (state == ST_ENCODE);
  end

  assign locked = (state == ST_HOLD);

  // R6: the load step follows a capture by exactly one cycle
  assert_load_after_capture_R6: assert property (@(posedge clk) disable iff (rst)
    strobes.capture |=> strobes.load);

  // R7: once holding, the controller never starts another measurement
  assert_hold_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);
endmodule

// File: rtl/chain_enc_datapath.sv
module chain_enc_datapath
  import chain_enc_pkg::*;
#(
  parameter int NUM_TAPS   = 16,
  parameter int NUM_RANGES = 4,
  parameter int COUNT_W    = $clog2(NUM_TAPS + 1),
  parameter int CODE_W     = $clog2(NUM_RANGES)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  ctrlStrobes_t                  strobes,
  input  logic [NUM_TAPS-1:0]           tapIn,
  input  logic [NUM_RANGES*COUNT_W-1:0] rangeLimits,
  output logic [NUM_TAPS-1:0]           tapSnapshot,
  output logic [COUNT_W-1:0]            unitCount,
  output logic [CODE_W-1:0]             rangeCode,
  output logic                          chainOverflow,
  output logic                          measDone
);
  localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(NUM_RANGES - 1);

  logic [COUNT_W-1:0] runLen;
  logic               runActive;
  logic [CODE_W-1:0]  pickCode;
  logic               allHigh;

  // leading run of ones from tap 0; bubbles above the first zero drop out
  always_comb begin
    runLen    = '0;
    runActive = 1'b1;
    for (int i = 0; i < NUM_TAPS; i++) begin
      if (runActive && tapSnapshot[i]) runLen = COUNT_W'(i + 1);
      else runActive = 1'b0;
    end
  end

  assign allHigh = &tapSnapshot;

  // smallest range whose limit covers the run; scan downward so the lowest wins
  always_comb begin
    pickCode = TOP_CODE;
    for (int r = NUM_RANGES - 1; r >= 0; r--) begin
      if (rangeLimits[r*COUNT_W +: COUNT_W] >= runLen) pickCode = CODE_W'(r);
    end
    if (allHigh) pickCode = TOP_CODE;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      tapSnapshot   <= '0;
      unitCount     <= '0;
      rangeCode     <= '0;
      chainOverflow <= 1'b0;
      measDone      <= 1'b0;
    end else begin
      if (strobes.capture) tapSnapshot <= tapIn;
      if (strobes.load) begin
        unitCount     <= runLen;
        rangeCode     <= pickCode;
        chainOverflow <= allHigh;
      end
      measDone <= strobes.load;
    end
  end

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    measDone |=> !measDone);

  assert_overflow_code_R5: assert property (@(posedge clk) disable iff (rst)
    chainOverflow |-> (rangeCode == TOP_CODE && unitCount == COUNT_W'(NUM_TAPS)));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    unitCount <= COUNT_W'(NUM_TAPS));
endmodule

// File: rtl/delay_chain_encoder.sv
module delay_chain_encoder
  import chain_enc_pkg::*;
#(
  parameter int NUM_TAPS   = 16,
  parameter int NUM_RANGES = 4,
  parameter int COUNT_W    = $clog2(NUM_TAPS + 1),
  parameter int CODE_W     = $clog2(NUM_RANGES)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          measPulse,
  input  logic [NUM_TAPS-1:0]           tapIn,
  input  logic [NUM_RANGES*COUNT_W-1:0] rangeLimits,
  output logic [NUM_TAPS-1:0]           tapSnapshot,
  output logic [COUNT_W-1:0]            unitCount,
  output logic [CODE_W-1:0]             rangeCode,
  output logic                          chainOverflow,
  output logic                          measDone
);
  ctrlStrobes_t strobes;
  logic         locked;

  chain_enc_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .measPulse (measPulse),
    .strobes   (strobes),
    .locked    (locked)
  );

  chain_enc_datapath #(
    .NUM_TAPS   (NUM_TAPS),
    .NUM_RANGES (NUM_RANGES),
    .COUNT_W    (COUNT_W),
    .CODE_W     (CODE_W)
  ) u_dp (
    .clk           (clk),
    .rst           (rst),
    .strobes       (strobes),
    .tapIn         (tapIn),
    .rangeLimits   (rangeLimits),
    .tapSnapshot   (tapSnapshot),
    .unitCount     (unitCount),
    .rangeCode     (rangeCode),
    .chainOverflow (chainOverflow),
    .measDone      (measDone)
  );

  assert_results_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (locked && !measDone) |=> ($stable(tapSnapshot) && $stable(unitCount)
                               && $stable(rangeCode) && $stable(chainOverflow) && !measDone));

  assert_done_needs_capture_R6: assert property (@(posedge clk) disable iff (rst)
    measDone |-> $past(strobes.load));
endmodule

// File: tb/delay_chain_encoder_test.sv
module delay_chain_encoder_test;
  localparam int NT = 16;
  localparam int NR = 4;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          measPulse = 1'b0;
  logic [NT-1:0] tapIn = '0;
  logic [NR*CW-1:0] rangeLimits = '0;
  logic [NT-1:0] tapSnapshot;
  logic [CW-1:0] unitCount;
  logic [1:0]    rangeCode;
  logic          chainOverflow;
  logic          measDone;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  delay_chain_encoder uut (
    .clk(clk), .rst(rst), .measPulse(measPulse), .tapIn(tapIn),
    .rangeLimits(rangeLimits), .tapSnapshot(tapSnapshot), .unitCount(unitCount),
    .rangeCode(rangeCode), .chainOverflow(chainOverflow), .measDone(measDone)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int expCode(input int len, input logic [NR*CW-1:0] lims);
    if (len == NT) return NR - 1;
    for (int r = 0; r < NR; r++)
      if (int'(lims[r*CW +: CW]) >= len) return r;
    return NR - 1;
  endfunction

  function automatic logic [NT-1:0] makeTaps(input int len, input logic [NT-1:0] junk);
    logic [NT-1:0] t;
    for (int i = 0; i < NT; i++) begin
      if (i < len) t[i] = 1'b1;
      else if (i == len) t[i] = 1'b0;
      else t[i] = junk[i];
    end
    return t;
  endfunction

  task automatic runOne(input int len, input logic [NR*CW-1:0] lims, input logic [NT-1:0] junk);
    logic [NT-1:0] taps;
    int ec;
    int eo;
    taps = makeTaps(len, junk);
    ec = expCode(len, lims);
    eo = (len == NT) ? 1 : 0;
    @(negedge clk); rst = 1'b1; measPulse = 1'b0; rangeLimits = lims;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 and R8: cleared state after reset
    chk(tapSnapshot == '0 && unitCount == '0 && rangeCode == '0 && !chainOverflow && !measDone,
        "R1/R8 reset state", int'(tapSnapshot) + int'(unitCount) + int'(measDone), 0);
    measPulse = 1'b1; tapIn = ~taps;
    @(negedge clk); tapIn = taps;
    @(negedge clk); measPulse = 1'b0;
    chk(tapSnapshot == '0 && !measDone, "R2 no capture while high", int'(tapSnapshot), 0);
    @(negedge clk);
    chk(tapSnapshot == taps, "R2 snapshot at capture edge", int'(tapSnapshot), int'(taps));
    chk(!measDone, "R6 done not early", int'(measDone), 0);
    tapIn = ~taps;
    @(negedge clk);
    chk(measDone, "R6 done strobe", int'(measDone), 1);
    chk(int'(unitCount) == len, "R3 unit count", int'(unitCount), len);
    chk(int'(rangeCode) == ec, "R4 range code", int'(rangeCode), ec);
    chk(int'(chainOverflow) == eo, "R5 overflow flag", int'(chainOverflow), eo);
    @(negedge clk);
    chk(!measDone, "R6 done one cycle", int'(measDone), 0);
    chk(tapSnapshot == taps, "R2 later tap change ignored", int'(tapSnapshot), int'(taps));
    // R7: another pulse with other taps must change nothing
    measPulse = 1'b1; tapIn = ~taps;
    @(negedge clk); measPulse = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!measDone, "R7 no second done", int'(measDone), 0);
    end
    chk(tapSnapshot == taps && int'(unitCount) == len && int'(rangeCode) == ec
        && int'(chainOverflow) == eo, "R7 results frozen", int'(unitCount), len);
  endtask

  initial begin
    logic [NR*CW-1:0] limSets [3];
    logic [NT-1:0] junks [3];
    limSets[0] = {5'd15, 5'd11, 5'd7, 5'd3};
    limSets[1] = {5'd20, 5'd4, 5'd4, 5'd0};
    limSets[2] = {5'd5, 5'd3, 5'd2, 5'd1};
    junks[0] = 16'hFFFF;
    junks[1] = 16'hA5C3;
    junks[2] = 16'h0000;
    for (int s = 0; s < 3; s++)
      for (int len = 0; len <= NT; len++)
        runOne(len, limSets[s], junks[(len + s) % 3]);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule